// File: doc/BRIEF.md
# Pulse Rate Meter by Period Reciprocal

This block turns a slow, asynchronous pulse train into a pulses-per-minute figure. It counts system clock cycles between consecutive rising edges of the pulse line. When an edge arrives it divides a fixed constant by that count. The constant is one minute expressed in clock periods: 1,500,000,000 at 25 MHz. The division is a sequential loop that subtracts one step per clock. A new rate is therefore ready shortly after every pulse, rather than at the end of a counting window.

The pulse input is first brought into the clock domain through a flop chain, and rising edges are found there. The first edge after reset only starts timing. Each later edge hands its period to the divider. An edge that arrives while a divide is still running restarts the divide with the newer period. If the line stays quiet longer than the slowest supported period, the block flags the input as out of range and shows a rate of zero until a valid period is measured again. Digit conversion and display driving are left to the blocks downstream.

Top module: `pulse_rate_meter`

## Requirements
- R1: After reset, and until the first result, `rate` is 0 and `rate_valid`, `busy` and `out_of_range` are all low.
- R2: The first rising edge of `pulse_in` after reset produces no `rate_valid` strobe. It only starts the period measurement.
- R3: When two rising edges of `pulse_in` lie P clock cycles apart, with 1 <= P <= MAX_PERIOD, the result reported for the later edge is floor(DIVIDEND / P), truncated.
- R4: When floor(DIVIDEND / P) exceeds 2^RATE_W - 1, the reported rate is clamped to 2^RATE_W - 1 (all ones).
- R5: Every result comes with a `rate_valid` strobe exactly one cycle wide. Two strobes never fall on adjacent cycles. `busy` is high while a divide runs and is low in the cycle that carries the strobe.
- R6: Once more than MAX_PERIOD cycles pass after the most recent edge, `out_of_range` goes high and `rate` reads 0. Both stay that way until a valid result is strobed, which clears `out_of_range`.
- R7: An edge whose period exceeds MAX_PERIOD gives a `rate_valid` strobe with `rate` 0 and `out_of_range` high. A period of exactly MAX_PERIOD is still valid.
- R8: An edge that arrives during a running divide restarts the divide with the new period. Only the result for the new period is strobed, and the abandoned divide produces none.
- R9: Between strobes, and while `out_of_range` is low, `rate` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one count per period |
| rst_n | input | 1 | Synchronous reset, active low |
| pulse_in | input | 1 | Asynchronous pulse line whose rising edges are timed |
| rate | output | RATE_W | Latest pulses-per-minute result, truncated and clamped |
| rate_valid | output | 1 | One-cycle strobe marking a new `rate` |
| busy | output | 1 | High while the divider loop is running |
| out_of_range | output | 1 | Period longer than MAX_PERIOD seen or under way |

## Verification
The divider has a single quotient register, so a wrong remainder or a wrong stop condition appears directly as a wrong value with the next strobe. That strobe comes about floor(DIVIDEND / P) + 3 cycles after the edge reaches the pins. A corrupted period counter or arming flag shows up either as a strobe for the first edge or as a quotient for the wrong spacing. A wrong over-range threshold shows up within one cycle of the limit being crossed, through `out_of_range` and a zero `rate`. The sweep walks the period from deep in the clamp region up to one cycle past the limit, in a reduced configuration, so that each of these faults changes a compared value.

// File: rtl/prm_pkg.sv
// Package: shared types and helpers for the pulse rate meter.
// Assumes: nothing beyond IEEE 1800-2017 elaboration.
package prm_pkg;

    // Divider sequencing state
    typedef enum logic {
        DIV_IDLE = 1'b0,
        DIV_RUN  = 1'b1
    } div_state_t;

    // Larger of two widths, used to size the divider datapath
    function automatic int wider(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/prm_sync_edge.sv
// Module: prm_sync_edge
// Brings an asynchronous line into the clock domain through STAGES flops.
// Flags a rising edge for one cycle by comparing the synchronized level
// with the sample taken one clock earlier.
// Assumes: the input stays high and low for at least two clocks each.
module prm_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);

    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    // Shift the raw line through the synchronizer and one history flop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], async_in};
        end
    end

    // Rising edge when the synced level is high and the previous sample low
    always_comb begin
        rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
    end

endmodule

// File: rtl/prm_period_cnt.sv
// Module: prm_period_cnt
// Counts clocks since the last detected edge. The count reloads to 1 on an
// edge, so the value seen at the next edge equals the edge spacing. The
// count saturates at all ones. The first edge after reset only arms the
// block. Each later edge is classified as in range (start a divide) or over
// range.
// Assumes: MAX_PERIOD < 2**CNT_W - 1, so that saturation lies above the limit.
module prm_period_cnt #(
    parameter int CNT_W      = 27,
    parameter int MAX_PERIOD = 100_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    output logic             start_o,
    output logic             over_edge_o,
    output logic             over_now_o,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] LIMIT   = CNT_W'(MAX_PERIOD);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;
    logic             beyond;

    // Period counter: reload on an edge, otherwise count up and hold at the top
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (rise_i) begin
            cnt_q <= CNT_ONE;
        end else if (cnt_q != CNT_TOP) begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

    // Arming flag: set by the first edge, so later edges carry a period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (rise_i) begin
            armed_q <= 1'b1;
        end
    end

    // Classify the running count against the slowest supported period
    always_comb begin
        beyond      = armed_q && (cnt_q > LIMIT);
        start_o     = rise_i && armed_q && !beyond;
        over_edge_o = rise_i && beyond;
        over_now_o  = beyond;
        count_o     = cnt_q;
    end

endmodule

// File: rtl/prm_divider.sv
// Module: prm_divider
// Divides the constant DIVIDEND by a period count through repeated
// subtraction, one step per clock. Stops when the remainder drops below the
// divisor or the quotient reaches all ones, which bounds the loop length.
// A start restarts the loop at once; abort drops it with no result.
// Assumes: the divisor given with start is nonzero.
module prm_divider
    import prm_pkg::*;
#(
    parameter int      CNT_W    = 27,
    parameter int      RATE_W   = 10,
    parameter longint  DIVIDEND = 1_500_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              abort_i,
    input  logic [CNT_W-1:0]  divisor_i,
    output logic              busy_o,
    output logic              finish_o,
    output logic [RATE_W-1:0] quot_o
);

    localparam int                DIV_W = $clog2(DIVIDEND + 1);
    localparam int                W     = wider(DIV_W, CNT_W);
    localparam logic [W-1:0]      NUMER = W'(DIVIDEND);
    localparam logic [RATE_W-1:0] QMAX  = '1;
    localparam logic [RATE_W-1:0] QONE  = RATE_W'(1);

    div_state_t        state_q;
    logic [W-1:0]      rem_q;
    logic [W-1:0]      dvs_q;
    logic [RATE_W-1:0] quo_q;
    logic              step_ok;

    // Decide whether one more subtraction is allowed this cycle
    always_comb begin
        step_ok  = (rem_q >= dvs_q) && (quo_q != QMAX);
        busy_o   = (state_q == DIV_RUN);
        finish_o = (state_q == DIV_RUN) && !step_ok && !start_i && !abort_i;
        quot_o   = quo_q;
    end

    // Loop sequencer: load on start, subtract per clock, stop when done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DIV_IDLE;
            rem_q   <= '0;
            dvs_q   <= '0;
            quo_q   <= '0;
        end else if (start_i) begin
            state_q <= DIV_RUN;
            rem_q   <= NUMER;
            dvs_q   <= W'(divisor_i);
            quo_q   <= '0;
        end else if (abort_i) begin
            state_q <= DIV_IDLE;
        end else if (state_q == DIV_RUN) begin
            if (step_ok) begin
                rem_q <= rem_q - dvs_q;
                quo_q <= quo_q + QONE;
            end else begin
                state_q <= DIV_IDLE;
            end
        end
    end

endmodule

// File: rtl/pulse_rate_meter.sv
// Module: pulse_rate_meter (top)
// Measures the spacing of rising edges on pulse_in in clock cycles and
// reports DIVIDEND / spacing as a pulses-per-minute rate after every edge.
// Holds the published rate, its strobe and the out-of-range flag.
// Assumes: DIVIDEND equals one minute in clock periods, and pulse_in is
// slow compared with the clock.
module pulse_rate_meter #(
    parameter int     CNT_W      = 27,
    parameter int     RATE_W     = 10,
    parameter longint DIVIDEND   = 1_500_000_000,
    parameter int     MAX_PERIOD = 100_000_000,
    parameter int     SYNC_STG   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pulse_in,
    output logic [RATE_W-1:0] rate,
    output logic              rate_valid,
    output logic              busy,
    output logic              out_of_range
);

    logic              rise;
    logic              start;
    logic              over_edge;
    logic              over_now;
    logic [CNT_W-1:0]  period;
    logic              div_finish;
    logic [RATE_W-1:0] div_quot;

    logic [RATE_W-1:0] rate_q;
    logic              valid_q;
    logic              oor_q;

    prm_sync_edge #(
        .STAGES (SYNC_STG)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pulse_in),
        .rise_o   (rise)
    );

    prm_period_cnt #(
        .CNT_W      (CNT_W),
        .MAX_PERIOD (MAX_PERIOD)
    ) u_period (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_i      (rise),
        .start_o     (start),
        .over_edge_o (over_edge),
        .over_now_o  (over_now),
        .count_o     (period)
    );

    prm_divider #(
        .CNT_W    (CNT_W),
        .RATE_W   (RATE_W),
        .DIVIDEND (DIVIDEND)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .abort_i   (over_now),
        .divisor_i (period),
        .busy_o    (busy),
        .finish_o  (div_finish),
        .quot_o    (div_quot)
    );

    // Result register: publish quotients, force zero while over range
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q  <= '0;
            valid_q <= 1'b0;
            oor_q   <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (div_finish) begin
                rate_q  <= div_quot;
                valid_q <= 1'b1;
                oor_q   <= 1'b0;
            end else if (over_edge) begin
                rate_q  <= '0;
                valid_q <= 1'b1;
                oor_q   <= 1'b1;
            end else if (over_now) begin
                rate_q  <= '0;
                oor_q   <= 1'b1;
            end
        end
    end

    // Drive the outputs from the result register
    always_comb begin
        rate         = rate_q;
        rate_valid   = valid_q;
        out_of_range = oor_q;
    end

endmodule

// File: rtl/prm_checker.sv
// Module: prm_checker
// Port-level properties of the pulse rate meter, bound to every instance.
// Assumes: it is attached through the bind statement below.
module prm_checker #(
    parameter int RATE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [RATE_W-1:0] rate,
    input logic              rate_valid,
    input logic              busy,
    input logic              out_of_range
);

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rate_valid |=> !rate_valid); // R5

    AST_STROBE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rate_valid |-> !busy); // R5

    AST_OOR_ZERO_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        out_of_range |-> (rate == '0)); // R6

    AST_RATE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rate_valid && !out_of_range) |-> $stable(rate)); // R9

    AST_OOR_CLEARS_ON_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_of_range) |-> rate_valid); // R6

endmodule

bind pulse_rate_meter prm_checker #(
    .RATE_W (RATE_W)
) u_prm_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .rate         (rate),
    .rate_valid   (rate_valid),
    .busy         (busy),
    .out_of_range (out_of_range)
);

// File: tb/pulse_rate_meter_bench.sv
// Bench: sweeps the edge spacing in a small configuration and compares each
// strobed rate with floor(DIVIDEND / P), clamped to the rate width.
module pulse_rate_meter_bench;

    localparam int     CNT_W  = 10;
    localparam int     RATE_W = 8;
    localparam longint DIVD   = 2000;
    localparam int     MAXP   = 300;
    localparam int     QMAX   = (1 << RATE_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pulse_in = 1'b0;
    logic [RATE_W-1:0] rate;
    logic              rate_valid;
    logic              busy;
    logic              out_of_range;

    int checks = 0;
    int failures = 0;
    int nstrobe = 0;
    int last_rate = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pulse_rate_meter #(
        .CNT_W      (CNT_W),
        .RATE_W     (RATE_W),
        .DIVIDEND   (DIVD),
        .MAX_PERIOD (MAXP)
    ) u_pulse_rate_meter (
        .clk          (clk),
        .rst_n        (rst_n),
        .pulse_in     (pulse_in),
        .rate         (rate),
        .rate_valid   (rate_valid),
        .busy         (busy),
        .out_of_range (out_of_range)
    );

    // Strobe monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && rate_valid) begin
            nstrobe   <= nstrobe + 1;
            last_rate <= int'(rate);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Rising edge now; the next call's edge comes p cycles later
    task automatic edge_wait(input int p);
        @(negedge clk);
        pulse_in = 1'b1;
        @(negedge clk);
        pulse_in = 1'b0;
        repeat (p - 2) @(negedge clk);
    endtask

    function automatic int expect_rate(input int p);
        int q;
        q = int'(DIVD) / p;
        return (q > QMAX) ? QMAX : q;
    endfunction

    // Two edges p apart, then wait for the strobe of the second one
    task automatic measure(input int p, input string req);
        int n0;
        int t;
        int exp;
        exp = (p > MAXP) ? 0 : expect_rate(p);
        edge_wait(p);
        n0 = nstrobe;
        edge_wait(4);
        check({req, " busy during divide"}, int'(busy), (p > MAXP) ? 0 : 1);
        t = 0;
        while (nstrobe == n0 && t < 700) begin
            @(negedge clk);
            t++;
        end
        check({req, " one strobe"}, nstrobe - n0, 1);
        check({req, " rate value"}, last_rate, exp);
        check({req, " range flag"}, int'(out_of_range), (p > MAXP) ? 1 : 0);
        if (p <= MAXP) begin
            repeat (20) @(negedge clk);
            check("R9 rate held", int'(rate), exp);
            check("R9 no extra strobe", nstrobe - n0, 1);
        end
        repeat (340) @(negedge clk);
        check("R6 over range flag", int'(out_of_range), 1);
        check("R6 rate zero", int'(rate), 0);
    endtask

    initial begin
        int n0;
        repeat (3) @(negedge clk);
        check("R1 rate", int'(rate), 0);
        check("R1 valid", int'(rate_valid), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 range", int'(out_of_range), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R2: the first edge only arms the block
        n0 = nstrobe;
        edge_wait(60);
        check("R2 no strobe on first edge", nstrobe - n0, 0);
        check("R2 rate still zero", int'(rate), 0);
        repeat (300) @(negedge clk);

        // R3 and R4: sweep spacing across clamp and normal regions
        measure(6, "R4 clamp p6");
        measure(7, "R4 clamp p7");
        for (int p = 8; p <= MAXP; p += 7) begin
            measure(p, "R3 sweep");
        end
        measure(MAXP, "R7 at limit");
        measure(MAXP + 1, "R7 past limit");

        // R8: a new edge during a running divide restarts it
        edge_wait(6);
        n0 = nstrobe;
        edge_wait(10);
        edge_wait(4);
        repeat (400) @(negedge clk);
        check("R8 single strobe after restart", nstrobe - n0, 1);
        check("R8 restarted result", last_rate, expect_rate(10));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hang counts as a failed check
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule